// File: doc/BRIEF.md
# Boot Jump Byte Injector

The block sits between the memory read data path and the data input of an 8-bit processor. After power-on clear, and after later resets when the re-arm option is set, it replaces the first three bytes the processor reads. Those bytes form an absolute jump instruction. Its target is a 256-byte-aligned address whose upper byte comes from an 8-bit strap input. Once the third byte has been delivered, the block returns the data path to ordinary memory data and stays out of the way until the next qualifying reset.

A single state flop, `handed_off`, controls the block. Power-on clear drops it asynchronously. A synchronous system reset drops it only when the re-arm option is set. It rises when a read strobe at the handoff address (2) ends. Memory data is gated off inside the block during injection, so the memory never needs a disable signal.

The read path has no flow control: `rd_stb` is a plain level that qualifies `cpu_addr`. The block never stalls a read and never asks for one. The injected byte is valid for as long as the strobe is held. `jmp_en`, `rearm_en` and `page_sw` are straps that are expected to stay static while the processor runs.

Top module: `boot_jump_inject`

## Requirements
- R1: While `por_n` is low, `handed_off` is cleared. With `jmp_en` = 1, the next reads after `por_n` is released return injected bytes.
- R2: While injecting, a read whose `cpu_addr[1:0]` = 2'b00 returns the jump opcode 8'hC3.
- R3: While injecting, a read whose `cpu_addr[1:0]` = 2'b01 returns 8'h00, the low byte of the target.
- R4: While injecting, a read whose `cpu_addr[1:0]` = 2'b10 returns `page_sw`, the high byte of the target. `page_sw[7]` is target bit 15.
- R5: Injection ends at the first rising clock edge at which `rd_stb` is sampled low after a strobe at `cpu_addr` = 2. The third byte stays valid for every cycle of that strobe.
- R6: Once injection has ended, `cpu_data` equals `mem_data` until the block is re-armed.
- R7: `sys_rst` sampled high with `rearm_en` = 1 re-arms injection. With `rearm_en` = 0, `sys_rst` changes nothing.
- R8: With `jmp_en` = 0, `cpu_data` always equals `mem_data`.
- R9: While injecting, a read whose `cpu_addr[1:0]` = 2'b11 returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| por_n | input | 1 | Power-on clear, active low, asynchronous |
| sys_rst | input | 1 | System reset, active high, synchronous |
| jmp_en | input | 1 | Enables the boot jump feature |
| rearm_en | input | 1 | Makes `sys_rst` re-arm the jump |
| page_sw | input | 8 | Target address bits 15..8 |
| cpu_addr | input | 16 | Processor address |
| rd_stb | input | 1 | Read strobe, active high |
| mem_data | input | 8 | Data from memory |
| cpu_data | output | 8 | Data to the processor |

## Verification
The bench sweeps every combination of the two enables against a spread of strap values. It checks all three injected bytes, the unused slot, and the handback that follows.

- A design that ends injection on the leading edge of the address-2 strobe would corrupt the target byte in the second cycle of a held strobe.
- A design that ends injection on any address with low bits 10 would fail the repeated reads.
- A design that lets `sys_rst` re-arm without the option would replay the jump opcode instead of memory data.
- A design that fails to gate memory data would leak the memory pattern into the opcode slot.

// File: rtl/boot_jump_pkg.sv
package boot_jump_pkg;
  typedef enum logic [1:0] {
    SLOT_OPC = 2'd0,
    SLOT_LO  = 2'd1,
    SLOT_HI  = 2'd2,
    SLOT_PAD = 2'd3
  } slot_e;

  localparam logic [7:0] JUMP_OPCODE = 8'hC3;
  localparam logic [7:0] LOW_BYTE    = 8'h00;
  localparam logic [7:0] PAD_BYTE    = 8'h00;
endpackage

// File: rtl/bji_arm_ctrl.sv
module bji_arm_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int HANDOFF_ADDR = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst,
  input  logic              rearm_en,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              rd_stb,
  output logic              handed_off
);
  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(HANDOFF_ADDR);

  logic rd_q;
  logic hit_q;
  logic trail_hit;
  logic rearm;

  assign trail_hit = rd_q & ~rd_stb & hit_q;
  assign rearm     = sys_rst & rearm_en;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_q       <= 1'b0;
      hit_q      <= 1'b0;
      handed_off <= 1'b0;
    end else begin
      rd_q <= rd_stb;
      if (rd_stb) hit_q <= (cpu_addr == HIT);
      if (rearm) handed_off <= 1'b0;
      else if (trail_hit) handed_off <= 1'b1;
    end
  end

  // R5
  done_on_trail_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(handed_off) |-> ($past(rd_stb, 2) && !$past(rd_stb)));

  // R7
  rearm_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && rearm_en) |=> !handed_off);

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (handed_off && !(sys_rst && rearm_en)) |=> handed_off);
endmodule

// File: rtl/bji_byte_mux.sv
module bji_byte_mux #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        slot,
  input  logic              inject,
  input  logic [DATA_W-1:0] page_sw,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] cpu_data
);
  import boot_jump_pkg::*;

  logic [DATA_W-1:0] inj_byte;

  always_comb begin
    unique case (slot_e'(slot))
      SLOT_OPC: inj_byte = DATA_W'(JUMP_OPCODE);
      SLOT_LO:  inj_byte = DATA_W'(LOW_BYTE);
      SLOT_HI:  inj_byte = page_sw;
      default:  inj_byte = DATA_W'(PAD_BYTE);
    endcase
  end

  assign cpu_data = inject ? inj_byte : mem_data;
endmodule

// File: rtl/boot_jump_inject.sv
module boot_jump_inject #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int HANDOFF_ADDR = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst,
  input  logic              jmp_en,
  input  logic              rearm_en,
  input  logic [DATA_W-1:0] page_sw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] cpu_data
);
  import boot_jump_pkg::*;

  logic handed_off;
  logic inject;

  bji_arm_ctrl #(.ADDR_W(ADDR_W), .HANDOFF_ADDR(HANDOFF_ADDR)) u_ctrl (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .rearm_en(rearm_en),
    .cpu_addr(cpu_addr), .rd_stb(rd_stb), .handed_off(handed_off)
  );

  assign inject = jmp_en & ~handed_off;

  bji_byte_mux #(.DATA_W(DATA_W)) u_mux (
    .slot(cpu_addr[1:0]), .inject(inject), .page_sw(page_sw),
    .mem_data(mem_data), .cpu_data(cpu_data)
  );

  // R8
  off_passthru_chk: assert property (@(posedge clk) disable iff (!por_n)
    !jmp_en |-> (cpu_data == mem_data));

  // R2
  opcode_slot_chk: assert property (@(posedge clk) disable iff (!por_n)
    (jmp_en && !handed_off && cpu_addr[1:0] == 2'b00) |-> (cpu_data == DATA_W'(JUMP_OPCODE)));

  // R4
  page_slot_chk: assert property (@(posedge clk) disable iff (!por_n)
    (jmp_en && !handed_off && cpu_addr[1:0] == 2'b10) |-> (cpu_data == page_sw));
endmodule

// File: tb/boot_jump_inject_bench.sv
module boot_jump_inject_bench;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst = 1'b0;
  logic        jmp_en = 1'b0;
  logic        rearm_en = 1'b0;
  logic [7:0]  page_sw = 8'h00;
  logic [15:0] cpu_addr = 16'h0000;
  logic        rd_stb = 1'b0;
  logic [7:0]  mem_data = 8'h00;
  logic [7:0]  cpu_data;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit exp_inj = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  boot_jump_inject u_boot_jump_inject (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .jmp_en(jmp_en),
    .rearm_en(rearm_en), .page_sw(page_sw), .cpu_addr(cpu_addr),
    .rd_stb(rd_stb), .mem_data(mem_data), .cpu_data(cpu_data)
  );

  function automatic logic [7:0] mem_pat(input logic [15:0] a);
    return a[7:0] ^ 8'h5A ^ {a[15:8]};
  endfunction

  function automatic logic [7:0] expect_byte(input logic [15:0] a);
    if (!exp_inj) return mem_pat(a);
    case (a[1:0])
      2'b00: return 8'hC3;
      2'b01: return 8'h00;
      2'b10: return page_sw;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (cpu_data !== exp) begin
      n_bad++;
      $display("FAIL %s en=%0b rearm=%0b page=%02h addr=%04h got=%02h exp=%02h",
               req, jmp_en, rearm_en, page_sw, cpu_addr, cpu_data, exp);
    end
  endtask

  // Read held for two cycles; the byte is checked in both cycles.
  task automatic do_read(input logic [15:0] a, input string req);
    @(negedge clk);
    cpu_addr = a; mem_data = mem_pat(a); rd_stb = 1'b1;
    #1 check(req, expect_byte(a));
    @(negedge clk);
    #1 check({req, "/R5 held"}, expect_byte(a));
    rd_stb = 1'b0;
    if (a == 16'd2) exp_inj = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_por();
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    exp_inj = jmp_en;
  endtask

  task automatic pulse_rst();
    @(negedge clk);
    sys_rst = 1'b1;
    @(negedge clk);
    sys_rst = 1'b0;
    if (rearm_en) exp_inj = jmp_en;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int p = 0; p < 256; p += 15) begin
        jmp_en = cfg[0]; rearm_en = cfg[1]; page_sw = 8'(p);
        pulse_por();
        // R1 reset state: opcode slot after power-on clear
        @(negedge clk);
        cpu_addr = 16'h0000; mem_data = mem_pat(16'h0000);
        #1 check(jmp_en ? "R1" : "R8", expect_byte(16'h0000));
        do_read(16'h0000, "R2");
        do_read(16'h0001, "R3");
        do_read(16'h0003, "R9");
        do_read(16'h0006, "R4 no-handoff");
        do_read(16'h0002, "R4");
        do_read(16'h0002, "R6");
        do_read(16'h0000, "R6");
        do_read(16'h1235, "R6");
        pulse_rst();
        do_read(16'h0000, "R7");
        do_read(16'h0001, "R7");
        do_read(16'h0002, "R7");
        do_read(16'h0000, "R6 after R7");
      end
    end
    finish_run();
  end
endmodule